// File: doc/BRIEF.md
# Timer Alarm and Periodic Pulse Unit

This block sits next to a free-running 64-bit time counter and turns its value into timed outputs. Two alarm comparators each hold a 64-bit compare value. Each one fires a single one-cycle pulse on its own pin when the time first reaches that value, and the pin can idle high or low. Two periodic pulse generators count ticks, which are the clock cycles in which the counter enable is high. Each emits a one-cycle pulse every N ticks. The pulse signals are also exported on a second port so that a trigger capture block can loop them back.

All alarm, pulse and external trigger events land in one sticky event register. Writing a one to a bit of that register clears it. A mask register selects which events drive the single interrupt line. Software programs the block through a simple single-cycle register port. A compare value takes effect only when its upper word is written, so a 64-bit value is never half updated. Pulse intervals are frozen while the timer is enabled.

Top module: `tmr_alarm_pulse`

## Requirements
- R1: After reset both alarm compare values and both pulse intervals read 0xFFFFFFFF in every word, the event, mask and polarity registers read zero, and no alarm or pulse output is active.
- R2: Register addresses: 0 polarity (bit k for alarm k), 1 event, 2 mask, 4/5 alarm 0 low/high word, 6/7 alarm 1 low/high word, 8/9 pulse 0/1 interval. Any other address reads zero. Reads are combinational from the current address.
- R3: A low-word write is only staged. The compare value, as read back, changes when the high word is written, and it then becomes {high, staged low}.
- R4: A committed alarm fires once, in the cycle after a clock edge at which time_i >= compare. Its output is active for exactly one cycle, and it does not fire again until its high word is written anew.
- R5: A compare value of all ones never fires, even when time_i equals all ones.
- R6: Polarity bit k = 0 makes alarm pin k active high, idle low. Polarity bit k = 1 makes it active low, idle high.
- R7: A pulse generator with interval N, where 1 <= N <= 0xFFFFFFFE, drives a one-cycle pulse on pp_o and pp_loop_o after every Nth tick. Intervals 0 and 0xFFFFFFFF never pulse.
- R8: A pulse generator's tick count holds while en_i is low and restarts from zero on the first tick after en_i rises.
- R9: A write to an interval register while en_i is high is ignored.
- R10: Event bits are 0/1 alarm 0/1, 2/3 pulse 0/1 and 4/5 trigger 0/1. A bit is set in the same cycle its output pulse appears, or one cycle after trig_i[k] is high. Writing a one clears a bit, and a set in the same cycle wins over the clear.
- R11: irq_o is high exactly when some event bit and its mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| time_i | input | 64 | Current time from the time counter |
| en_i | input | 1 | Counter enable; a high cycle is one tick |
| trig_i | input | 2 | External trigger capture strobes |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| alm_o | output | 2 | Alarm pins, polarity applied |
| pp_o | output | 2 | Periodic pulse pins |
| pp_loop_o | output | 2 | Periodic pulses exported for trigger loopback |
| irq_o | output | 1 | Interrupt, OR of masked events |

## Verification
The bench goes after a compare value written in its low word only. A design that commits early would fire from a half-written value or show the new value on readback. It also places a compare value behind the current time: an alarm that tests for equality instead of greater-or-equal would stay silent, and one that forgets to disarm would pulse on every cycle. It runs the time through the all-ones value with an all-ones compare armed, which catches a design that treats all ones as a real target. For the pulse generators it stops the timer mid-period and restarts it, which exposes a count that is not reset, and it writes an interval while the timer is enabled, which exposes a period that changes under a running timer. A clear and a set on the same event bit in one cycle shows whether the event is lost.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned NUM_ALM = 2;
  localparam int unsigned NUM_PP  = 2;
  localparam int unsigned NUM_TRG = 2;

  // event register layout: alarms, then pulses, then triggers
  localparam int unsigned EVT_ALM_LSB = 0;
  localparam int unsigned EVT_PP_LSB  = NUM_ALM;
  localparam int unsigned EVT_TRG_LSB = NUM_ALM + NUM_PP;
  localparam int unsigned EVT_W       = NUM_ALM + NUM_PP + NUM_TRG;

  localparam logic [ADDR_W-1:0] A_CTRL     = 4'h0;
  localparam logic [ADDR_W-1:0] A_EVENT    = 4'h1;
  localparam logic [ADDR_W-1:0] A_MASK     = 4'h2;
  localparam logic [ADDR_W-1:0] A_ALM_BASE = 4'h4;  // lo at +2k, hi at +2k+1
  localparam logic [ADDR_W-1:0] A_PER_BASE = 4'h8;  // interval k at +k
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/tmr_alarm_cmp.sv
module tmr_alarm_cmp #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2*DATA_W-1:0]   time_i,
  input  logic                  wr_lo_i,
  input  logic                  wr_hi_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic                  fire_o,
  output logic                  hit_o,
  output logic [2*DATA_W-1:0]   cmp_o
);
  localparam int unsigned TIME_W = 2 * DATA_W;

  logic [DATA_W-1:0] stage_q, stage_d;
  logic [TIME_W-1:0] cmp_q, cmp_d;
  logic              armed_q, armed_d;
  logic              hit_q, hit_d;
  logic              fire;

  // all-ones is the parked value and never matches
  assign fire = armed_q && (cmp_q != '1) && (time_i >= cmp_q);

  always_comb begin
    stage_d = stage_q;
    cmp_d   = cmp_q;
    armed_d = armed_q & ~fire;
    hit_d   = fire;
    if (wr_lo_i) stage_d = wdata_i;
    if (wr_hi_i) begin
      cmp_d   = {wdata_i, stage_q};
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '1;
      cmp_q   <= '1;
      armed_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      cmp_q   <= cmp_d;
      armed_q <= armed_d;
      hit_q   <= hit_d;
    end
  end

  assign fire_o = fire;
  assign hit_o  = hit_q;
  assign cmp_o  = cmp_q;
endmodule

// File: rtl/tmr_pulse_gen.sv
module tmr_pulse_gen #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             en_rise_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic             fire_o,
  output logic             pulse_o,
  output logic [CNT_W-1:0] per_o
);
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q;
  logic [CNT_W-1:0] base, nxt;
  logic             per_ok;
  logic             fire;

  assign per_ok = (per_q != '0) && (per_q != '1);
  assign base   = en_rise_i ? '0 : cnt_q;
  assign nxt    = base + CNT_W'(1);
  assign fire   = en_i && per_ok && (nxt == per_q);

  always_comb begin
    per_d = per_q;
    cnt_d = cnt_q;
    if (wr_i && !en_i) per_d = wdata_i;
    if (en_i)          cnt_d = fire ? '0 : nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q   <= '1;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      per_q   <= per_d;
      cnt_q   <= cnt_d;
      pulse_q <= fire;
    end
  end

  assign fire_o  = fire;
  assign pulse_o = pulse_q;
  assign per_o   = per_q;
endmodule

// File: rtl/tmr_evt_reg.sv
module tmr_evt_reg #(
  parameter int unsigned EVT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] set_i,
  input  logic             clr_we_i,
  input  logic             mask_we_i,
  input  logic [EVT_W-1:0] wdata_i,
  output logic [EVT_W-1:0] evt_o,
  output logic [EVT_W-1:0] mask_o,
  output logic             irq_o
);
  logic [EVT_W-1:0] evt_q, evt_d;
  logic [EVT_W-1:0] mask_q, mask_d;
  logic [EVT_W-1:0] clr;

  assign clr = clr_we_i ? wdata_i : '0;

  always_comb begin
    evt_d  = (evt_q & ~clr) | set_i;
    mask_d = mask_we_i ? wdata_i : mask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      evt_q  <= evt_d;
      mask_q <= mask_d;
    end
  end

  assign evt_o  = evt_q;
  assign mask_o = mask_q;
  assign irq_o  = |(evt_q & mask_q);
endmodule

// File: rtl/tmr_alarm_pulse.sv
module tmr_alarm_pulse
  import tmr_evt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2*DATA_W-1:0]   time_i,
  input  logic                  en_i,
  input  logic [NUM_TRG-1:0]    trig_i,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic [NUM_ALM-1:0]    alm_o,
  output logic [NUM_PP-1:0]     pp_o,
  output logic [NUM_PP-1:0]     pp_loop_o,
  output logic                  irq_o
);
  localparam int unsigned TIME_W = 2 * DATA_W;

  logic                           rst_n;
  logic                           en_q;
  logic                           en_rise;
  logic [NUM_ALM-1:0]             pol_q, pol_d;
  logic [NUM_ALM-1:0]             alm_fire, alm_hit;
  logic [NUM_ALM-1:0][TIME_W-1:0] cmp_w;
  logic [NUM_PP-1:0]              pp_fire, pp_pulse;
  logic [NUM_PP-1:0][DATA_W-1:0]  per_w;
  logic [EVT_W-1:0]               evt_set, evt_q, mask_q;
  logic                           evt_clr_we, mask_we;

  tmr_rst_sync u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_n)
  );

  // timer enable edge restarts the pulse counters
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_i;
  end
  assign en_rise = en_i & ~en_q;

  // polarity register
  always_comb begin
    pol_d = pol_q;
    if (reg_we_i && reg_addr_i == A_CTRL) pol_d = reg_wdata_i[NUM_ALM-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) pol_q <= '0;
    else        pol_q <= pol_d;
  end

  for (genvar k = 0; k < NUM_ALM; k++) begin : g_alm
    localparam logic [ADDR_W-1:0] ALO = A_ALM_BASE + ADDR_W'(2 * k);
    localparam logic [ADDR_W-1:0] AHI = A_ALM_BASE + ADDR_W'(2 * k + 1);
    tmr_alarm_cmp #(.DATA_W(DATA_W)) u_alm (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .time_i (time_i),
      .wr_lo_i(reg_we_i && reg_addr_i == ALO),
      .wr_hi_i(reg_we_i && reg_addr_i == AHI),
      .wdata_i(reg_wdata_i),
      .fire_o (alm_fire[k]),
      .hit_o  (alm_hit[k]),
      .cmp_o  (cmp_w[k])
    );
    assign alm_o[k] = alm_hit[k] ^ pol_q[k];
  end

  for (genvar k = 0; k < NUM_PP; k++) begin : g_pp
    localparam logic [ADDR_W-1:0] APER = A_PER_BASE + ADDR_W'(k);
    tmr_pulse_gen #(.CNT_W(DATA_W)) u_pp (
      .clk_i    (clk_i),
      .rst_ni   (rst_n),
      .en_i     (en_i),
      .en_rise_i(en_rise),
      .wr_i     (reg_we_i && reg_addr_i == APER),
      .wdata_i  (reg_wdata_i),
      .fire_o   (pp_fire[k]),
      .pulse_o  (pp_pulse[k]),
      .per_o    (per_w[k])
    );
  end

  assign pp_o      = pp_pulse;
  assign pp_loop_o = pp_pulse;

  assign evt_set[EVT_ALM_LSB +: NUM_ALM] = alm_fire;
  assign evt_set[EVT_PP_LSB  +: NUM_PP ] = pp_fire;
  assign evt_set[EVT_TRG_LSB +: NUM_TRG] = trig_i;
  assign evt_clr_we = reg_we_i && reg_addr_i == A_EVENT;
  assign mask_we    = reg_we_i && reg_addr_i == A_MASK;

  tmr_evt_reg #(.EVT_W(EVT_W)) u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .set_i    (evt_set),
    .clr_we_i (evt_clr_we),
    .mask_we_i(mask_we),
    .wdata_i  (reg_wdata_i[EVT_W-1:0]),
    .evt_o    (evt_q),
    .mask_o   (mask_q),
    .irq_o    (irq_o)
  );

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_CTRL)  reg_rdata_o = DATA_W'(pol_q);
    if (reg_addr_i == A_EVENT) reg_rdata_o = DATA_W'(evt_q);
    if (reg_addr_i == A_MASK)  reg_rdata_o = DATA_W'(mask_q);
    for (int k = 0; k < NUM_ALM; k++) begin
      if (reg_addr_i == A_ALM_BASE + ADDR_W'(2 * k))
        reg_rdata_o = cmp_w[k][DATA_W-1:0];
      if (reg_addr_i == A_ALM_BASE + ADDR_W'(2 * k + 1))
        reg_rdata_o = cmp_w[k][TIME_W-1:DATA_W];
    end
    for (int k = 0; k < NUM_PP; k++) begin
      if (reg_addr_i == A_PER_BASE + ADDR_W'(k)) reg_rdata_o = per_w[k];
    end
  end
endmodule

// File: rtl/tmr_alarm_pulse_chk.sv
module tmr_alarm_pulse_chk
  import tmr_evt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             en_i,
  input logic                             reg_we_i,
  input logic [ADDR_W-1:0]                reg_addr_i,
  input logic [NUM_ALM-1:0]               alm_o,
  input logic [NUM_ALM-1:0]               pol_q,
  input logic [NUM_PP-1:0]                pp_o,
  input logic [EVT_W-1:0]                 evt_q,
  input logic [NUM_PP-1:0][DATA_W-1:0]    per_w,
  input logic [NUM_ALM-1:0][2*DATA_W-1:0] cmp_w
);
  logic [NUM_ALM-1:0] act;
  assign act = alm_o ^ pol_q;

  for (genvar k = 0; k < NUM_ALM; k++) begin : g_alm_chk
    localparam logic [ADDR_W-1:0] AHI = A_ALM_BASE + ADDR_W'(2 * k + 1);

    AST_ALM_SINGLE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act[k] && !$past(reg_we_i && reg_addr_i == AHI) |=> !act[k]);  // R4

    AST_ALLONES_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_w[k] == '1) |=> !act[k]);  // R5
  end

  for (genvar k = 0; k < NUM_PP; k++) begin : g_pp_chk
    AST_PULSE_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pp_o[k] |-> $past(en_i));  // R7

    AST_INTERVAL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |=> $stable(per_w[k]));  // R9
  end

  for (genvar i = 0; i < EVT_W; i++) begin : g_evt_chk
    AST_EVENT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_q[i] && !(reg_we_i && reg_addr_i == A_EVENT) |=> evt_q[i]);  // R10
  end
endmodule

bind tmr_alarm_pulse tmr_alarm_pulse_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .reg_we_i  (reg_we_i),
  .reg_addr_i(reg_addr_i),
  .alm_o     (alm_o),
  .pol_q     (pol_q),
  .pp_o      (pp_o),
  .evt_q     (evt_q),
  .per_w     (per_w),
  .cmp_w     (cmp_w)
);

// File: tb/tmr_alarm_pulse_tb_top.sv
`timescale 1ns/1ps
module tmr_alarm_pulse_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [63:0] time_i;
  logic        en_i;
  logic [1:0]  trig_i;
  logic        reg_we_i;
  logic [3:0]  reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic [1:0]  alm_o, pp_o, pp_loop_o;
  logic        irq_o;

  always #2.5 clk_i = ~clk_i;

  tmr_alarm_pulse dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .time_i(time_i), .en_i(en_i),
    .trig_i(trig_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .alm_o(alm_o),
    .pp_o(pp_o), .pp_loop_o(pp_loop_o), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // bench-side expected state
  logic [63:0] b_time;
  logic        b_en;
  logic [31:0] m_stage [2];
  logic [63:0] m_cmp   [2];
  logic [31:0] m_per   [2];
  logic [31:0] m_cnt   [2];
  logic [1:0]  m_armed, m_hit, m_pp, m_pol;
  logic [5:0]  m_evt, m_mask;
  logic        m_enq;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a)
      4'h0: return {30'd0, m_pol};
      4'h1: return {26'd0, m_evt};
      4'h2: return {26'd0, m_mask};
      4'h4: return m_cmp[0][31:0];
      4'h5: return m_cmp[0][63:32];
      4'h6: return m_cmp[1][31:0];
      4'h7: return m_cmp[1][63:32];
      4'h8: return m_per[0];
      4'h9: return m_per[1];
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      m_stage[k] = '1; m_cmp[k] = '1; m_per[k] = '1; m_cnt[k] = '0;
    end
    m_armed = 0; m_hit = 0; m_pp = 0; m_pol = 0; m_evt = 0; m_mask = 0; m_enq = 0;
  endtask

  task automatic model_step(input logic en, input logic [63:0] t, input logic we,
                            input logic [3:0] a, input logic [31:0] wd, input logic [1:0] trig);
    logic [1:0]  fa, fp;
    logic [31:0] nxt [2];
    logic [5:0]  clr;
    for (int k = 0; k < 2; k++) begin
      fa[k]  = m_armed[k] && (m_cmp[k] != '1) && (t >= m_cmp[k]);
      nxt[k] = ((en && !m_enq) ? 32'd0 : m_cnt[k]) + 32'd1;
      fp[k]  = en && (m_per[k] != 0) && (m_per[k] != '1) && (nxt[k] == m_per[k]);
    end
    clr = (we && a == 4'h1) ? wd[5:0] : 6'd0;
    m_evt = (m_evt & ~clr) | {trig, fp, fa};
    for (int k = 0; k < 2; k++) begin
      if (fa[k]) m_armed[k] = 1'b0;
      if (we && a == 4'(4 + 2*k + 1)) begin
        m_cmp[k] = {wd, m_stage[k]}; m_armed[k] = 1'b1;
      end
      if (we && a == 4'(4 + 2*k)) m_stage[k] = wd;
      if (en) m_cnt[k] = fp[k] ? 32'd0 : nxt[k];
      if (we && a == 4'(8 + k) && !en) m_per[k] = wd;
    end
    if (we && a == 4'h2) m_mask = wd[5:0];
    if (we && a == 4'h0) m_pol = wd[1:0];
    m_hit = fa; m_pp = fp; m_enq = en;
  endtask

  task automatic compare_all();
    chk("R4 R6 alarm pins", 64'(alm_o), 64'(m_hit ^ m_pol));
    chk("R7 R8 pulse pins", 64'(pp_o), 64'(m_pp));
    chk("R7 loopback pins", 64'(pp_loop_o), 64'(m_pp));
    chk("R11 irq", 64'(irq_o), 64'(|(m_evt & m_mask)));
    chk("R2 R3 readback", 64'(reg_rdata_o), 64'(exp_read(reg_addr_i)));
  endtask

  task automatic drive(input logic we, input logic [3:0] a, input logic [31:0] wd, input logic [1:0] trig);
    reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd; trig_i = trig;
    en_i = b_en; time_i = b_time;
    model_step(b_en, b_time, we, a, wd, trig);
    if (b_en) b_time = b_time + 64'd1;
    @(negedge clk_i);
    compare_all();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] wd);
    drive(1'b1, a, wd, 2'b00);
  endtask

  task automatic rd(input logic [3:0] a);
    drive(1'b0, a, 32'd0, 2'b00);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int cnt, first;
    void'($urandom(32'h1588));
    rst_ni = 0; en_i = 0; time_i = 0; trig_i = 0;
    reg_we_i = 0; reg_addr_i = 0; reg_wdata_i = 0;
    b_time = 0; b_en = 0;
    model_reset();
    repeat (4) @(negedge clk_i);
    rst_ni = 1;
    repeat (3) rd(4'h0);

    // R1 reset state
    rd(4'h4); chk("R1 alarm0 lo", 64'(reg_rdata_o), 64'hFFFF_FFFF);
    rd(4'h7); chk("R1 alarm1 hi", 64'(reg_rdata_o), 64'hFFFF_FFFF);
    rd(4'h9); chk("R1 interval1", 64'(reg_rdata_o), 64'hFFFF_FFFF);
    rd(4'h1); chk("R1 event", 64'(reg_rdata_o), 64'd0);
    chk("R1 pins idle", 64'({alm_o, pp_o, irq_o}), 64'd0);
    rd(4'h3); chk("R2 unmapped", 64'(reg_rdata_o), 64'd0);

    // R3 staging, R4 single fire on a past compare
    b_time = 64'd100; b_en = 1;
    wr(4'h2, 32'h3F);
    wr(4'h4, 32'd120);
    rd(4'h4); chk("R3 lo staged only", 64'(reg_rdata_o), 64'hFFFF_FFFF);
    repeat (25) rd(4'h1);
    chk("R3 no fire before commit", 64'(reg_rdata_o[0]), 64'd0);
    wr(4'h5, 32'd0);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin rd(4'h4); if (alm_o[0]) cnt++; end
    chk("R4 one pulse", 64'(cnt), 64'd1);
    chk("R3 committed lo", 64'(reg_rdata_o), 64'd120);
    rd(4'h1); chk("R10 alarm0 event", 64'(reg_rdata_o[0]), 64'd1);
    chk("R11 irq raised", 64'(irq_o), 64'd1);

    // R5 all-ones compare across the time wrap
    wr(4'h1, 32'h3F);
    wr(4'h6, 32'hFFFF_FFFF); wr(4'h7, 32'hFFFF_FFFF);
    b_time = 64'hFFFF_FFFF_FFFF_FFF0;
    repeat (30) rd(4'h1);
    chk("R5 no alarm1 event", 64'(reg_rdata_o[1]), 64'd0);

    // R6 polarity
    wr(4'h0, 32'h1);
    chk("R6 active-low idles high", 64'(alm_o), 64'h1);
    wr(4'h4, b_time[31:0] + 32'd10); wr(4'h5, b_time[63:32]);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin rd(4'h0); if (!alm_o[0]) cnt++; end
    chk("R6 one low pulse", 64'(cnt), 64'd1);

    // R7 periodic pulses
    b_en = 0; rd(4'h8);
    wr(4'h8, 32'd5); wr(4'h9, 32'd3);
    b_en = 1;
    cnt = 0; first = 0;
    for (int i = 0; i < 40; i++) begin
      rd(4'h8); if (pp_o[0]) cnt++; if (pp_o[1]) first++;
    end
    chk("R7 interval 5 count", 64'(cnt), 64'd8);
    chk("R7 interval 3 count", 64'(first), 64'd13);

    // R9 write ignored while enabled
    wr(4'h8, 32'd2);
    rd(4'h8); chk("R9 interval unchanged", 64'(reg_rdata_o), 64'd5);

    // R8 restart on enable
    b_en = 0; repeat (7) rd(4'h8);
    b_en = 1; first = 0;
    for (int i = 1; i <= 10; i++) begin
      rd(4'h8); if (pp_o[0] && first == 0) first = i;
    end
    chk("R8 first pulse after restart", 64'(first), 64'd5);

    // R10 clear, trigger, set over clear; R11 mask
    b_en = 0; rd(4'h1);
    wr(4'h1, 32'h3F);
    rd(4'h1); chk("R10 cleared", 64'(reg_rdata_o), 64'd0);
    chk("R11 irq low", 64'(irq_o), 64'd0);
    drive(1'b0, 4'h1, 32'd0, 2'b10);
    chk("R10 trigger1 event", 64'(reg_rdata_o), 64'h20);
    drive(1'b1, 4'h1, 32'h20, 2'b10);
    chk("R10 set wins", 64'(reg_rdata_o), 64'h20);
    wr(4'h2, 32'h0);
    chk("R11 masked", 64'(irq_o), 64'd0);

    // random phase against the expected-state model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if ($urandom_range(0, 19) == 0) b_en = ~b_en;
      if (r < 8) begin
        int k;
        k = int'($urandom_range(0, 1));
        wr(4'(4 + 2*k), b_time[31:0] + 32'($urandom_range(0, 40)));
        wr(4'(5 + 2*k), b_time[63:32]);
      end else if (r < 13) begin
        logic [31:0] v;
        v = ($urandom_range(0, 9) == 0) ? 32'hFFFF_FFFF : 32'($urandom_range(0, 12));
        wr(4'(8 + $urandom_range(0, 1)), v);
      end else if (r < 18) wr(4'h1, 32'($urandom_range(0, 63)));
      else if (r < 21) wr(4'h2, 32'($urandom_range(0, 63)));
      else if (r < 23) wr(4'h0, 32'($urandom_range(0, 3)));
      else drive(1'b0, 4'($urandom_range(0, 15)), 32'd0,
                 ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule